// File: doc/BRIEF.md
# Serial ADC Host Frame Sequencer

This block is the host side of a serial link to a multi-instruction analog-to-digital converter. It drives an active-low chip select, a serial clock and a serial instruction line. It samples the converter's serial data line. A command handshake starts each exchange. The command carries an 8-bit instruction word, a chip-select mode and a flag saying whether this exchange returns a conversion result. It can also carry a new output word format: 12 or 16 data bits, a sign bit on or off, and most- or least-significant bit first.

The number of clock pulses in an exchange is not fixed. A result-bearing exchange, and every exchange in the held-low chip-select mode, runs for the full output word: 12, 13, 16 or 17 pulses. With chip select strobed, an exchange that only carries an instruction stops after 8 pulses. A format sent with a command takes effect only from the exchange after it, as on the converter side. Received words are presented right-aligned, put back in natural bit order, and sign- or zero-extended.

Top module: `adcFrameSeq`

## Requirements
- R1: After reset, csN is 1, sclk is 0, and resultValid, cmdAck and cmdError are all 0. The active format after reset is 12 bits, sign off, MSB first.
- R2: An exchange that returns a result gives `base + sign` sclk pulses. Here base is 12 (cmdWide=0) or 16 (cmdWide=1), and sign is 1 when the sign bit is on.
- R3: With chip select strobed (cmdHoldLow=0) and cmdExpect=0, an exchange gives exactly 8 sclk pulses and raises no resultValid.
- R4: With cmdHoldLow=1, every exchange gives the full word length of pulses and returns a result. csN stays 0 after the exchange ends. sclk is never 1 while csN is 1.
- R5: A command with cmdLoadFmt=1 runs its own exchange with the previously active format. Its cmdWide, cmdSign and cmdLsbFirst values govern later exchanges. With cmdLoadFmt=0, those fields are ignored.
- R6: di carries cmdInstr bit 0 first and bit 7 eighth, then 0 for any further pulses. di changes only while sclk is 0.
- R7: doIn is sampled at each rising sclk edge. In MSB-first format, the first bit received is bit N-1 of result, where N is the pulse count.
- R8: In LSB-first format, the first bit received is bit 0 of result.
- R9: With sign on, result bits above N-1 copy bit N-1. With sign off, they are 0.
- R10: cmdReq while an exchange is running is ignored: there is no cmdAck and the running exchange is unchanged. cmdError is 1 for exactly one cycle.
- R11: An accepted cmdReq gives a one-cycle cmdAck pulse in the next cycle. In strobed mode, csN returns to 1 when the exchange ends.
- R12: sclk stays 1 for HALF_PERIOD system clock cycles per pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdReq | input | 1 | One-cycle command request |
| cmdInstr | input | INSTR_W | Instruction word to shift out |
| cmdLoadFmt | input | 1 | Adopt the format fields for later exchanges |
| cmdWide | input | 1 | 1 selects 16 data bits, 0 selects 12 |
| cmdSign | input | 1 | Sign bit on |
| cmdLsbFirst | input | 1 | Least significant bit transferred first |
| cmdHoldLow | input | 1 | Keep chip select low continuously |
| cmdExpect | input | 1 | Exchange returns a result (strobed mode) |
| cmdAck | output | 1 | Command accepted pulse |
| cmdError | output | 1 | Command arrived while busy pulse |
| csN | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| di | output | 1 | Serial instruction data |
| doIn | input | 1 | Serial data from converter |
| result | output | WIDE_BITS+1 | Right-aligned, extended result |
| resultValid | output | 1 | Result strobe |

## Verification
The assertions assume that cmdReq is a single-cycle pulse and that the format and mode fields matter only in the cycle a command is accepted. They also assume doIn is settled before each rising sclk edge. The stimulus meets this by raising cmdReq for one cycle at a time and driving the command fields in that same cycle. It advances doIn only right after a rising sclk edge has been sampled. The bench keeps its own model of the active format. It sweeps all eight formats under both chip-select modes and both result settings, and it places a second request inside a running exchange.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LOW  = 2'd1,
    SEQ_HIGH = 2'd2
  } seqState_t;

  typedef struct packed {
    logic load;
    logic rise;
    logic fall;
    logic finish;
  } seqStrobe_t;

endpackage

// File: rtl/adcSeqControl.sv
module adcSeqControl
  import adc_seq_pkg::*;
#(
  parameter int HALF_PERIOD = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdReq,
  input  logic       cmdHoldLow,
  input  logic       lastPulse,
  output seqStrobe_t stb,
  output logic       sclk,
  output logic       csN,
  output logic       cmdAck,
  output logic       cmdError
);

  localparam int PH_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF_PERIOD - 1);

  seqState_t       state;
  logic [PH_W-1:0] phCnt;
  logic            holdMode;
  logic            phEnd;

  always_comb begin
    phEnd      = (phCnt == PH_LAST);
    stb.load   = (state == SEQ_IDLE) && cmdReq;
    stb.rise   = (state == SEQ_LOW) && phEnd;
    stb.fall   = (state == SEQ_HIGH) && phEnd;
    stb.finish = (state == SEQ_HIGH) && phEnd && lastPulse;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= SEQ_IDLE;
      phCnt    <= '0;
      holdMode <= 1'b0;
      sclk     <= 1'b0;
      csN      <= 1'b1;
      cmdAck   <= 1'b0;
      cmdError <= 1'b0;
    end else begin
      cmdAck   <= stb.load;
      cmdError <= cmdReq && (state != SEQ_IDLE);
      case (state)
        SEQ_IDLE: begin
          if (stb.load) begin
            state    <= SEQ_LOW;
            phCnt    <= '0;
            csN      <= 1'b0;
            holdMode <= cmdHoldLow;
          end
        end
        SEQ_LOW: begin
          if (phEnd) begin
            state <= SEQ_HIGH;
            phCnt <= '0;
            sclk  <= 1'b1;
          end else begin
            phCnt <= phCnt + PH_W'(1);
          end
        end
        SEQ_HIGH: begin
          if (phEnd) begin
            sclk  <= 1'b0;
            phCnt <= '0;
            if (lastPulse) begin
              state <= SEQ_IDLE;
              csN   <= ~holdMode;
            end else begin
              state <= SEQ_LOW;
            end
          end else begin
            phCnt <= phCnt + PH_W'(1);
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R4: the serial clock only runs inside a selected frame
  assert_sclk_needs_cs_R4: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !csN);

  // R10: a rejected request never coincides with an acceptance
  assert_err_not_ack_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdError |-> !cmdAck);

  // R11: acceptance is a single-cycle pulse
  assert_ack_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    cmdAck |=> !cmdAck);

endmodule

// File: rtl/adcSeqDatapath.sv
module adcSeqDatapath
  import adc_seq_pkg::*;
#(
  parameter int INSTR_W     = 8,
  parameter int NARROW_BITS = 12,
  parameter int WIDE_BITS   = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           stb,
  input  logic [INSTR_W-1:0]   cmdInstr,
  input  logic                 cmdLoadFmt,
  input  logic                 cmdWide,
  input  logic                 cmdSign,
  input  logic                 cmdLsbFirst,
  input  logic                 cmdHoldLow,
  input  logic                 cmdExpect,
  input  logic                 doIn,
  output logic                 di,
  output logic                 lastPulse,
  output logic [WIDE_BITS:0]   result,
  output logic                 resultValid
);

  localparam int RES_W = WIDE_BITS + 1;
  localparam int CNT_W = $clog2(RES_W + 1);

  logic             fmtWide, fmtSign, fmtLsb;
  logic             exSign, exLsb, exHasRes;
  logic [CNT_W-1:0] exLen, pulsesLeft, wordLen;
  logic [INSTR_W-1:0] txShift;
  logic [RES_W-1:0] rxShift, ordered;
  logic             signBit;

  always_comb begin
    wordLen = (fmtWide ? CNT_W'(WIDE_BITS) : CNT_W'(NARROW_BITS)) + CNT_W'(fmtSign);
    signBit = exLsb ? rxShift[0] : rxShift[exLen - CNT_W'(1)];
    for (int i = 0; i < RES_W; i++) begin
      if (CNT_W'(i) < exLen)
        ordered[i] = exLsb ? rxShift[exLen - CNT_W'(1) - CNT_W'(i)] : rxShift[i];
      else
        ordered[i] = exSign & signBit;
    end
    lastPulse = (pulsesLeft == CNT_W'(1));
    di        = txShift[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fmtWide     <= 1'b0;
      fmtSign     <= 1'b0;
      fmtLsb      <= 1'b0;
      exSign      <= 1'b0;
      exLsb       <= 1'b0;
      exHasRes    <= 1'b0;
      exLen       <= CNT_W'(INSTR_W);
      pulsesLeft  <= '0;
      txShift     <= '0;
      rxShift     <= '0;
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= 1'b0;
      if (stb.load) begin
        exLen      <= (cmdHoldLow || cmdExpect) ? wordLen : CNT_W'(INSTR_W);
        pulsesLeft <= (cmdHoldLow || cmdExpect) ? wordLen : CNT_W'(INSTR_W);
        exHasRes   <= cmdHoldLow || cmdExpect;
        exSign     <= fmtSign;
        exLsb      <= fmtLsb;
        txShift    <= cmdInstr;
        rxShift    <= '0;
        if (cmdLoadFmt) begin
          fmtWide <= cmdWide;
          fmtSign <= cmdSign;
          fmtLsb  <= cmdLsbFirst;
        end
      end
      if (stb.rise) rxShift <= {rxShift[RES_W-2:0], doIn};
      if (stb.fall) begin
        txShift    <= {1'b0, txShift[INSTR_W-1:1]};
        pulsesLeft <= pulsesLeft - CNT_W'(1);
      end
      if (stb.finish) begin
        resultValid <= exHasRes;
        result      <= ordered;
      end
    end
  end

  // R2: the remaining-pulse count never exceeds the frame length
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    pulsesLeft <= exLen);

  // R3: a result is only presented for frames longer than the instruction
  assert_no_res_short_R3: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (exLen > CNT_W'(INSTR_W)));

endmodule

// File: rtl/adcFrameSeq.sv
module adcFrameSeq
  import adc_seq_pkg::*;
#(
  parameter int INSTR_W     = 8,
  parameter int NARROW_BITS = 12,
  parameter int WIDE_BITS   = 16,
  parameter int HALF_PERIOD = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdReq,
  input  logic [INSTR_W-1:0] cmdInstr,
  input  logic               cmdLoadFmt,
  input  logic               cmdWide,
  input  logic               cmdSign,
  input  logic               cmdLsbFirst,
  input  logic               cmdHoldLow,
  input  logic               cmdExpect,
  output logic               cmdAck,
  output logic               cmdError,
  output logic               csN,
  output logic               sclk,
  output logic               di,
  input  logic               doIn,
  output logic [WIDE_BITS:0] result,
  output logic               resultValid
);

  seqStrobe_t stb;
  logic       lastPulse;

  adcSeqControl #(.HALF_PERIOD(HALF_PERIOD)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdReq     (cmdReq),
    .cmdHoldLow (cmdHoldLow),
    .lastPulse  (lastPulse),
    .stb        (stb),
    .sclk       (sclk),
    .csN        (csN),
    .cmdAck     (cmdAck),
    .cmdError   (cmdError)
  );

  adcSeqDatapath #(
    .INSTR_W     (INSTR_W),
    .NARROW_BITS (NARROW_BITS),
    .WIDE_BITS   (WIDE_BITS)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .cmdInstr    (cmdInstr),
    .cmdLoadFmt  (cmdLoadFmt),
    .cmdWide     (cmdWide),
    .cmdSign     (cmdSign),
    .cmdLsbFirst (cmdLsbFirst),
    .cmdHoldLow  (cmdHoldLow),
    .cmdExpect   (cmdExpect),
    .doIn        (doIn),
    .di          (di),
    .lastPulse   (lastPulse),
    .result      (result),
    .resultValid (resultValid)
  );

  // R6: the instruction line holds still while the serial clock is high
  assert_di_steady_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(di));

endmodule

// File: tb/adcFrameSeq_test.sv
`timescale 1ns/1ps
module adcFrameSeq_test;

  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdReq = 1'b0;
  logic [7:0]  cmdInstr = '0;
  logic        cmdLoadFmt = 1'b0, cmdWide = 1'b0, cmdSign = 1'b0, cmdLsbFirst = 1'b0;
  logic        cmdHoldLow = 1'b0, cmdExpect = 1'b0;
  logic        cmdAck, cmdError, csN, sclk, di, doIn, resultValid;
  logic [16:0] result;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  int pulses = 0, bitIdx = 0;
  logic [31:0] diCap = '0, doPat = '0;
  int ackCnt = 0, errCnt = 0, resCnt = 0, highCnt = 0;
  logic [16:0] lastRes = '0;

  logic mWide = 1'b0, mSign = 1'b0, mLsb = 1'b0;

  always #2.5 clk = ~clk;

  adcFrameSeq #(.HALF_PERIOD(HALF)) uut (
    .clk(clk), .rstN(rstN), .cmdReq(cmdReq), .cmdInstr(cmdInstr),
    .cmdLoadFmt(cmdLoadFmt), .cmdWide(cmdWide), .cmdSign(cmdSign),
    .cmdLsbFirst(cmdLsbFirst), .cmdHoldLow(cmdHoldLow), .cmdExpect(cmdExpect),
    .cmdAck(cmdAck), .cmdError(cmdError), .csN(csN), .sclk(sclk), .di(di),
    .doIn(doIn), .result(result), .resultValid(resultValid)
  );

  assign doIn = (bitIdx < 32) ? doPat[bitIdx[4:0]] : 1'b0;

  always @(posedge sclk) begin
    if (pulses < 32) diCap[pulses[4:0]] = di;
    pulses = pulses + 1;
    bitIdx = bitIdx + 1;
  end

  always @(negedge clk) begin
    if (cmdAck) ackCnt = ackCnt + 1;
    if (cmdError) errCnt = errCnt + 1;
    if (sclk) highCnt = highCnt + 1;
    if (resultValid) begin
      resCnt = resCnt + 1;
      lastRes = result;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [16:0] expRes(input logic [31:0] pat, input int n,
                                         input logic sg, input logic lb);
    logic [16:0] v = '0;
    for (int k = 0; k < n; k++) begin
      if (lb) v[k] = pat[k];
      else v[n-1-k] = pat[k];
    end
    for (int i = n; i < 17; i++) v[i] = sg ? v[n-1] : 1'b0;
    return v;
  endfunction

  task automatic issue(input logic [7:0] ins, input logic ldf, input logic wd,
                       input logic sg, input logic lb, input logic hold,
                       input logic expct, input logic [31:0] pat);
    @(negedge clk);
    cmdInstr = ins; cmdLoadFmt = ldf; cmdWide = wd; cmdSign = sg;
    cmdLsbFirst = lb; cmdHoldLow = hold; cmdExpect = expct;
    doPat = pat; bitIdx = 0; pulses = 0; diCap = '0;
    cmdReq = 1'b1;
    @(negedge clk);
    cmdReq = 1'b0;
  endtask

  task automatic runEx(input logic [7:0] ins, input logic ldf, input logic wd,
                       input logic sg, input logic lb, input logic hold,
                       input logic expct, input logic [31:0] pat);
    int n;
    bit hasRes;
    int a0, r0, h0;
    string cntTag, resTag;
    logic [16:0] expV;
    logic eSign, eLsb;
    hasRes = hold || expct;
    eSign = mSign; eLsb = mLsb;
    n = hasRes ? ((mWide ? 16 : 12) + (mSign ? 1 : 0)) : 8;
    expV = expRes(pat, n, eSign, eLsb);
    cntTag = ldf ? "R5" : (hold ? "R4" : (expct ? "R2" : "R3"));
    resTag = eLsb ? "R8" : (eSign ? "R9" : "R7");
    a0 = ackCnt; r0 = resCnt; h0 = highCnt;
    issue(ins, ldf, wd, sg, lb, hold, expct, pat);
    if (ldf) begin mWide = wd; mSign = sg; mLsb = lb; end
    repeat (n * 2 * HALF + 4) @(negedge clk);
    chk(pulses == n, cntTag, "pulse count", pulses, n);
    chk(ackCnt == a0 + 1, "R11", "ack pulses", ackCnt - a0, 1);
    chk(highCnt - h0 == n * HALF, "R12", "sclk high cycles", highCnt - h0, n * HALF);
    chk(diCap[7:0] == ins, "R6", "instruction bits", diCap[7:0], ins);
    for (int k = 8; k < n; k++)
      chk(diCap[k] == 1'b0, "R6", "padding bit", diCap[k], 0);
    chk(csN == !hold, hold ? "R4" : "R11", "csN after exchange", csN, !hold);
    chk(resCnt - r0 == (hasRes ? 1 : 0), hasRes ? resTag : "R3", "result strobes",
        resCnt - r0, hasRes ? 1 : 0);
    if (hasRes) chk(lastRes == expV, resTag, "result value", lastRes, expV);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(csN == 1'b1, "R1", "reset csN", csN, 1);
    chk(sclk == 1'b0, "R1", "reset sclk", sclk, 0);
    chk(resultValid == 1'b0, "R1", "reset resultValid", resultValid, 0);
    chk(cmdAck == 1'b0 && cmdError == 1'b0, "R1", "reset ack/err",
        {cmdAck, cmdError}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: default format is 12 bits, no sign, MSB first
    runEx(8'h5A, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_0801);

    // sweep every format under both chip-select modes and result settings
    for (int f = 0; f < 8; f++) begin
      for (int h = 0; h < 2; h++) begin
        for (int e = 0; e < 2; e++) begin
          logic [31:0] pat;
          logic [7:0] ins;
          pat = 32'hA5C3_96E1 ^ (32'(f * 4 + h * 2 + e) * 32'h9E37_79B1);
          ins = 8'(8'h3C + f * 29 + h * 7 + e);
          runEx(ins, 1'b1, f[0], f[1], f[2], h[0], e[0], pat);
          runEx(~ins, 1'b0, ~f[0], ~f[1], ~f[2], h[0], e[0], ~pat);
        end
      end
    end

    // R9: explicit sign-extension corner cases
    runEx(8'h81, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
    runEx(8'h81, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0001);
    runEx(8'h81, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_1FFE);
    runEx(8'h18, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0001_0000);
    runEx(8'h18, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_FFFF);

    // R10: a request during a running exchange is ignored and flagged
    begin
      int a0, e0, n;
      n = (mWide ? 16 : 12) + (mSign ? 1 : 0);
      a0 = ackCnt; e0 = errCnt;
      issue(8'hC6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1234_5678);
      repeat (6) @(negedge clk);
      cmdInstr = 8'h39; cmdExpect = 1'b0; cmdReq = 1'b1;
      @(negedge clk);
      cmdReq = 1'b0;
      @(negedge clk);
      chk(errCnt == e0 + 1, "R10", "error pulses", errCnt - e0, 1);
      repeat (n * 2 * HALF + 4) @(negedge clk);
      chk(ackCnt == a0 + 1, "R10", "acks with rejected request", ackCnt - a0, 1);
      chk(pulses == n, "R10", "pulse count unchanged", pulses, n);
      chk(diCap[7:0] == 8'hC6, "R10", "instruction unchanged", diCap[7:0], 8'hC6);
      chk(errCnt == e0 + 1, "R10", "error stays single", errCnt - e0, 1);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule